// File: doc/BRIEF.md
# Dual Counter Timer with Match Interrupts

This block holds two independent 16-bit counters, six shared compare registers and a small interrupt unit. Each counter has a loadable count, a prescale divider and a control word. The control word sets three things: whether the counter is halted or running, which way it counts, and how the run ends. A run can end when the count reaches zero, or when it reaches one of the six compare values, or it can never end and wrap around instead. When a counter reaches its selected compare value it stops and raises one bit in the interrupt status register. Each status bit can be masked before it reaches the interrupt line.

Software accesses the block through a single-cycle register bus. Writes take effect on the clock edge that samples them. The data for a read is returned one cycle after the request. The bus has two spaces: the timer space and the interrupt space. A select input chooses between them. The bus carries word addresses, so byte offset = 4 × word address.

A typical one-shot use runs in four steps: halt the counter, load a start count and a divider, choose a compare register, then release the counter with a control write.

Top module: `dual_match_timer`

## Requirements
- R1: Timer space word map. Counter 0 uses words 0, 1 and 2 (count, divider, control). Counter 1 uses words 3, 4 and 5 in the same order. Compare register k is at word 6+k, for k = 0..5. Interrupt space word map: word 0 is status, word 1 is mask. Every written register reads back its value. Read data appears on `bus_rdata` in the cycle after the request. Unmapped words read as 0.
- R2: Control bit 4 set means halted. A halted counter holds its count and its prescaler stays cleared.
- R3: Control bit 3 set counts up, clear counts down. Both directions wrap modulo 2^16.
- R4: For a divider value D, a running counter steps once every D+1 clocks, counted from the control write that released it. D = 0 steps on every clock.
- R5: Control bits 2:0 = 7 is free-run mode. The counter never stops and wraps around.
- R6: Control bits 2:0 = 0 is zero-terminated mode. A step that lands on 0 stops the counter at 0 and sets no status bit.
- R7: Control bits 2:0 = m, for m in 1..6, is compare mode. A step that lands on compare register m-1 stops the counter and sets status bit m-1 on that same edge. The counter stays stopped, even if its count is reloaded, until its control register is written again.
- R8: Writing the count loads it on the next edge, even while the counter runs, and restarts the prescaler. The next step follows D+1 clocks later.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R10: `irq` is a register that takes the OR of (status AND mask) one clock after that term changes. The mask gates only the line, never the status bits.
- R11: After reset both control words read 0x10 (halted, down, mode 0). All other registers read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_isel | input | 1 | 1 = interrupt space, 0 = timer space |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after a read request |
| irq | output | 1 | Registered interrupt request |

## Verification
A corrupted prescaler or direction bit shows up as a count that is off by a whole step, at the first readback after the run starts. The bench therefore compares counts at exact clock offsets from the releasing write. A wrong termination flag appears as a counter that overruns its target, or that restarts after a reload, within a few steps. Status and line faults appear one or two cycles after the arrival edge. The bench probes the status register on the cycle just before arrival and again on the arrival cycle.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int N_TMR        = 2;
  localparam int N_MATCH      = 6;
  localparam int MODE_W       = 3;
  localparam int CTL_W        = 5;
  localparam int REGS_PER_TMR = 3;
  localparam int MATCH_BASE   = N_TMR * REGS_PER_TMR;

  localparam logic [MODE_W-1:0] MODE_TO_ZERO = 3'd0;
  localparam logic [MODE_W-1:0] MODE_FREE    = 3'd7;

  typedef struct packed {
    logic              halt;
    logic              up;
    logic [MODE_W-1:0] mode;
  } tmr_ctl_t;

  localparam tmr_ctl_t CTL_RESET = '{halt: 1'b1, up: 1'b0, mode: MODE_TO_ZERO};
endpackage

// File: rtl/dmt_match_bank.sv
module dmt_match_bank
  import dmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_MATCH-1:0]             wr_sel,
  input  logic [CNT_W-1:0]               wdata,
  output logic [N_MATCH-1:0][CNT_W-1:0]  cmp_val
);
  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk) begin
      if (rst)            cmp_q <= '0;
      else if (wr_sel[k]) cmp_q <= wdata;
    end
    assign cmp_val[k] = cmp_q;
  end

  always_comb begin
    assert_one_select_R1: assert (rst || $onehot0(wr_sel));
  end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
  import dmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cnt_we,
  input  logic                           div_we,
  input  logic                           ctl_we,
  input  logic [CNT_W-1:0]               wdata,
  input  logic [N_MATCH-1:0][CNT_W-1:0]  cmp_val,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [DIV_W-1:0]               div_o,
  output logic [CTL_W-1:0]               ctl_o,
  output logic [N_MATCH-1:0]             hit_o
);
  tmr_ctl_t         ctl_q;
  logic [CNT_W-1:0] cnt_q, step_val, target;
  logic [DIV_W-1:0] div_q, pre_q;
  logic             ended_q, active, tick, bounded, arrive;

  assign active  = !ctl_q.halt && !ended_q;
  assign tick    = active && (pre_q >= div_q);
  assign step_val = ctl_q.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  assign bounded = (ctl_q.mode != MODE_FREE);

  always_comb begin
    target = '0;
    for (int k = 0; k < N_MATCH; k++) begin
      if (ctl_q.mode == MODE_W'(k + 1)) target = cmp_val[k];
    end
  end

  assign arrive = tick && bounded && (step_val == target);

  always_comb begin
    for (int k = 0; k < N_MATCH; k++) begin
      hit_o[k] = arrive && (ctl_q.mode == MODE_W'(k + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= CTL_RESET;
      ended_q <= 1'b0;
    end else if (ctl_we) begin
      ctl_q   <= tmr_ctl_t'(wdata[CTL_W-1:0]);
      ended_q <= 1'b0;
    end else if (arrive) begin
      ended_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '0;
    else if (div_we) div_q <= wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= wdata;
      pre_q <= '0;
    end else if (tick) begin
      cnt_q <= step_val;
      pre_q <= '0;
    end else if (active) begin
      pre_q <= pre_q + 1'b1;
    end else begin
      pre_q <= '0;
    end
  end

  assign cnt_o = cnt_q;
  assign div_o = div_q;
  assign ctl_o = ctl_q;

  assert_halt_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.halt && !cnt_we) |=> (cnt_q == $past(cnt_q)));

  assert_step_pace_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(cnt_we) && (cnt_q != $past(cnt_q))) |-> $past(pre_q >= div_q));

  assert_ended_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (ended_q && !cnt_we) |=> $stable(cnt_q));

  assert_single_hit_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_o));
endmodule

// File: rtl/dmt_irq.sv
module dmt_irq
  import dmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [N_MATCH-1:0] hit,
  input  logic               clr_we,
  input  logic               mask_we,
  input  logic [N_MATCH-1:0] wbits,
  output logic [N_MATCH-1:0] status_o,
  output logic [N_MATCH-1:0] mask_o,
  output logic               irq_o
);
  logic [N_MATCH-1:0] status_q, mask_q, clr_bits;
  logic               irq_q;

  assign clr_bits = clr_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_bits) | hit;
      if (mask_we) mask_q <= wbits;
      irq_q <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  assert_sticky_status_R9: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_hit_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

  assert_mask_gates_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_q);
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_isel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic                          wr_t, wr_i, rd;
  logic [N_MATCH-1:0]            cmp_sel;
  logic [N_MATCH-1:0][CNT_W-1:0] cmp_val;
  logic [N_TMR-1:0][CNT_W-1:0]   cnt_v;
  logic [N_TMR-1:0][DIV_W-1:0]   div_v;
  logic [N_TMR-1:0][CTL_W-1:0]   ctl_v;
  logic [N_TMR-1:0][N_MATCH-1:0] hit_v;
  logic [N_MATCH-1:0]            hit_any, status, mask;
  logic [CNT_W-1:0]              rd_mux, rdata_q;

  assign wr_t = bus_en && bus_we && !bus_isel;
  assign wr_i = bus_en && bus_we &&  bus_isel;
  assign rd   = bus_en && !bus_we;

  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp_sel
    assign cmp_sel[k] = wr_t && (bus_addr == ADDR_W'(MATCH_BASE + k));
  end

  dmt_match_bank #(.CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .wr_sel(cmp_sel), .wdata(bus_wdata), .cmp_val(cmp_val)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    localparam int BASE = t * REGS_PER_TMR;
    dmt_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .cnt_we (wr_t && (bus_addr == ADDR_W'(BASE))),
      .div_we (wr_t && (bus_addr == ADDR_W'(BASE + 1))),
      .ctl_we (wr_t && (bus_addr == ADDR_W'(BASE + 2))),
      .wdata  (bus_wdata),
      .cmp_val(cmp_val),
      .cnt_o  (cnt_v[t]),
      .div_o  (div_v[t]),
      .ctl_o  (ctl_v[t]),
      .hit_o  (hit_v[t])
    );
  end

  always_comb begin
    hit_any = '0;
    for (int t = 0; t < N_TMR; t++) hit_any = hit_any | hit_v[t];
  end

  dmt_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit_any),
    .clr_we  (wr_i && (bus_addr == ADDR_W'(0))),
    .mask_we (wr_i && (bus_addr == ADDR_W'(1))),
    .wbits   (bus_wdata[N_MATCH-1:0]),
    .status_o(status),
    .mask_o  (mask),
    .irq_o   (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_isel) begin
      if (bus_addr == ADDR_W'(0)) rd_mux = CNT_W'(status);
      if (bus_addr == ADDR_W'(1)) rd_mux = CNT_W'(mask);
    end else begin
      for (int t = 0; t < N_TMR; t++) begin
        if (bus_addr == ADDR_W'(t * REGS_PER_TMR))     rd_mux = cnt_v[t];
        if (bus_addr == ADDR_W'(t * REGS_PER_TMR + 1)) rd_mux = CNT_W'(div_v[t]);
        if (bus_addr == ADDR_W'(t * REGS_PER_TMR + 2)) rd_mux = CNT_W'(ctl_v[t]);
      end
      for (int k = 0; k < N_MATCH; k++) begin
        if (bus_addr == ADDR_W'(MATCH_BASE + k)) rd_mux = cmp_val[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  assert_rdata_held_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> $stable(bus_rdata));
endmodule

// File: tb/test_dual_match_timer.sv
`timescale 1ns/1ps
module test_dual_match_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0, bus_isel = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dual_match_timer i_dual_match_timer (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_isel(bus_isel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all R) actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit isel, input int a, input int d);
    bus_en = 1; bus_we = 1; bus_isel = isel; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input bit isel, input int a, output int d);
    bus_en = 1; bus_we = 0; bus_isel = isel; bus_addr = 4'(a);
    @(negedge clk);
    d = int'(bus_rdata);
    bus_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ctlw(input bit halt, input bit up, input int mode);
    return (int'(halt) << 4) | (int'(up) << 3) | (mode & 7);
  endfunction

  function automatic int exp_count(input int v, input int d, input int k, input bit up);
    int n = k / (d + 1);
    return up ? ((v + n) & 16'hFFFF) : ((v - n) & 16'hFFFF);
  endfunction

  // halt, load count and divider, then release; release edge is the last write
  task automatic start(input int ch, input int v, input int d, input bit up, input int mode);
    wr(0, ch*3+2, ctlw(1, up, mode));
    wr(0, ch*3+0, v);
    wr(0, ch*3+1, d);
    wr(0, ch*3+2, ctlw(0, up, mode));
  endtask

  initial begin
    int r, seed;
    seed = int'($urandom(32'h5EED1234));
    idle(3);
    rst = 0;
    idle(1);

    // R11 reset state
    rd(0, 2, r);  check("R11 ctl0 reset", r, 16'h10);
    rd(0, 5, r);  check("R11 ctl1 reset", r, 16'h10);
    rd(0, 0, r);  check("R11 cnt0 reset", r, 0);
    rd(1, 0, r);  check("R11 status reset", r, 0);
    check("R11 irq reset", int'(irq), 0);

    // R1 readback of compare bank, divider, mask, unmapped word
    for (int k = 0; k < 6; k++) begin
      int v = int'($urandom) & 16'hFFFF;
      wr(0, 6+k, v);
      rd(0, 6+k, r); check("R1 compare readback", r, v);
    end
    wr(0, 4, 16'h00A5); rd(0, 4, r); check("R1 divider1 readback", r, 16'h00A5);
    wr(1, 1, 6'h2A);    rd(1, 1, r); check("R1 mask readback", r, 6'h2A);
    wr(1, 1, 0);
    rd(0, 15, r); check("R1 unmapped reads zero", r, 0);

    // R2 halted counter holds
    wr(0, 2, ctlw(1, 0, 7));
    wr(0, 0, 100);
    idle(20);
    rd(0, 0, r); check("R2 halted count holds", r, 100);

    // R3 R4 R5 random free-run runs
    for (int it = 0; it < 10; it++) begin
      int ch = int'($urandom % 2);
      int v  = int'($urandom) & 16'hFFFF;
      int d  = int'($urandom % 6);
      bit up = bit'($urandom % 2);
      int k  = int'($urandom % 60);
      start(ch, v, d, up, 7);
      idle(k);
      rd(0, ch*3, r); check("R4 R3 R5 free-run count", r, exp_count(v, d, k, up));
    end
    start(0, 16'hFFFE, 0, 1, 7);
    idle(3);
    rd(0, 0, r); check("R3 R5 upward wrap", r, 16'h0001);
    start(0, 16'h0001, 0, 0, 7);
    idle(4);
    rd(0, 0, r); check("R3 downward wrap", r, 16'hFFFD);
    wr(0, 2, ctlw(1, 0, 7));
    wr(0, 5, ctlw(1, 0, 7));

    // R6 zero-terminated mode
    start(0, 5, 1, 0, 0);
    idle(30);
    rd(0, 0, r); check("R6 down stops at zero", r, 0);
    start(1, 16'hFFFD, 0, 1, 0);
    idle(10);
    rd(0, 3, r); check("R6 up wraps to zero and stops", r, 0);
    rd(1, 0, r); check("R6 no status bit", r, 0);

    // R7 compare mode with exact arrival edge
    wr(0, 8, 40);
    start(1, 50, 0, 0, 3);
    idle(9);
    rd(1, 0, r); check("R7 status before arrival", r, 0);
    rd(1, 0, r); check("R7 status on arrival", r, 16'h04);
    check("R10 masked line low", int'(irq), 0);
    rd(0, 3, r); check("R7 stopped at compare", r, 40);
    idle(10);
    rd(0, 3, r); check("R7 still stopped", r, 40);
    wr(1, 1, 16'h04);
    idle(1);
    check("R10 line rises after unmask", int'(irq), 1);
    wr(0, 3, 60);
    idle(5);
    rd(0, 3, r); check("R7 reload does not restart", r, 60);
    wr(0, 5, ctlw(0, 0, 3));
    idle(25);
    rd(0, 3, r); check("R7 control write restarts", r, 40);

    // R9 write-one-to-clear
    wr(1, 0, 0);
    rd(1, 0, r); check("R9 zero write keeps status", r, 16'h04);
    wr(1, 0, 16'h04);
    idle(1);
    check("R9 R10 line falls after clear", int'(irq), 0);
    rd(1, 0, r); check("R9 status cleared", r, 0);

    // R10 mask does not gate status
    wr(0, 6, 3);
    start(0, 5, 0, 0, 1);
    idle(5);
    rd(1, 0, r); check("R10 status independent of mask", r, 16'h01);
    check("R10 line low for unmasked-off bit", int'(irq), 0);
    wr(1, 0, 16'h3F);

    // R8 count write while running restarts prescaler
    start(0, 500, 3, 1, 7);
    idle(6);
    wr(0, 0, 1000);
    idle(9);
    rd(0, 0, r); check("R8 load while running", r, exp_count(1000, 3, 9, 1));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    if (seed == 0) $display("seed zero");
    $finish;
  end
endmodule